// File: doc/BRIEF.md
# Bit-Serial Wide Unsigned Divider

The block divides a double-width unsigned dividend (512 bits by default) by a single-width unsigned divisor (256 bits). It returns a single-width quotient and a single-width remainder. It uses a restoring shift-and-subtract method and produces one quotient bit per clock cycle. A request is accepted with a one-cycle `start_i` pulse while the block is idle. The operands are captured at that edge, so the caller may change the inputs straight afterwards.

Before any work starts, the operands are screened. The quotient must fit in the single-width result, so the divisor must be nonzero and the upper half of the dividend must be strictly below the divisor. A request that fails this screen completes on the next cycle with the error flag set. A valid request loads the whole dividend into a double-width working remainder and places the divisor, shifted up by W-1 bits, in a fixed double-width register. Each of the W iterations then does four things in order:

- tries a subtraction;
- shifts the quotient left and enters a 1 when no borrow occurs;
- keeps the difference as the new working remainder when no borrow occurs;
- shifts the working remainder left by one bit.

At the end, the true remainder sits in the upper half of the working remainder.

Top module: `wide_restoring_div`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o` and `err_o` are 0, and `quotient_o` and `remainder_o` are 0.
- R2: A start accepted with `divisor_i == 0`, or with `dividend_i[2W-1:W] >= divisor_i`, gives `done_o = 1` and `err_o = 1` on the cycle after the accepting edge. `busy_o` never rises, and `quotient_o` and `remainder_o` read 0.
- R3: A start accepted with valid operands raises `busy_o` for exactly W cycles. `done_o` is high, with `err_o = 0`, on the cycle after the last of those cycles, which is W+1 cycles after the accepting edge. `busy_o` and `done_o` are never high together.
- R4: For valid operands, `quotient_o` equals floor(dividend / divisor) and `remainder_o` equals dividend mod divisor while `done_o` is high.
- R5: Quotient bits are produced most significant first. After k iterations (k cycles after the load cycle), `quotient_o` equals the final quotient shifted right by W-k.
- R6: `done_o` is a single-cycle pulse. Once it falls, `quotient_o` and `remainder_o` hold their values until the next accepted start.
- R7: A start raised while `busy_o` is high is ignored. The running division finishes at its normal time with its original result and no error.
- R8: The corner cases give exact results:
  - a dividend of 2^(W-1) with a divisor of 1 gives a quotient of 2^(W-1) and a remainder of 0;
  - a dividend of 2^(2W-1)-1 with a divisor of 2^W-1 gives a quotient of 2^(W-1) and a remainder of 2^(W-1)-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, accepted only while idle |
| dividend_i | input | 2W | Unsigned dividend, captured at the accepting edge |
| divisor_i | input | W | Unsigned divisor, captured at the accepting edge |
| busy_o | output | 1 | High while iterations are in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Operands of the last request were invalid |
| quotient_o | output | W | Quotient (partial while busy) |
| remainder_o | output | W | Remainder, valid from `done_o` onwards |

## Verification
The assertions take for granted that the caller raises `start_i` only as a clean single-cycle request. They also take for granted that the operands are stable at the sampling edge. Under these conditions the latency window, the zeroed error result and the output hold are all observable at the ports. The stimulus draws the divisor from several ranges: full-width random, small, and the all-ones value. It draws the upper half of the dividend as a random value reduced modulo the divisor, which keeps every random request inside the valid region. Invalid requests come only from directed cases: a zero divisor, an upper half equal to the divisor, and an upper half greater than the divisor. A start is also injected in the middle of a run to show that it is ignored.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } wdiv_state_e;

endpackage

// File: rtl/wdiv_opcheck.sv
// Screens a request: the quotient fits only when the divisor is nonzero
// and the top half of the dividend lies strictly below the divisor.
module wdiv_opcheck #(
    parameter int W = 256
) (
    input  logic [2*W-1:0] dividend_i,
    input  logic [W-1:0]   divisor_i,
    output logic           valid_o
);
    logic div_zero;
    logic hi_fits;

    always_comb begin
        div_zero = (divisor_i == '0);
        hi_fits  = (dividend_i[2*W-1:W] < divisor_i);
        valid_o  = !div_zero && hi_fits;
    end
endmodule

// File: rtl/wdiv_align.sv
// Places the divisor W-1 bits up inside a double-width word.
module wdiv_align #(
    parameter int W = 256
) (
    input  logic [W-1:0]   divisor_i,
    output logic [2*W-1:0] aligned_o
);
    localparam int DW = 2 * W;

    always_comb begin
        aligned_o = DW'(divisor_i) << (W - 1);
    end
endmodule

// File: rtl/wdiv_step.sv
// One restoring iteration: trial subtract, quotient shift-in, remainder shift.
module wdiv_step #(
    parameter int W = 256
) (
    input  logic [2*W-1:0] rem_i,
    input  logic [2*W-1:0] aligned_i,
    input  logic [W-1:0]   quo_i,
    output logic [2*W-1:0] rem_o,
    output logic [W-1:0]   quo_o
);
    localparam int DW = 2 * W;

    logic [DW:0]   trial;
    logic          borrow;
    logic [DW-1:0] kept;

    always_comb begin
        trial  = {1'b0, rem_i} - {1'b0, aligned_i};
        borrow = trial[DW];
        kept   = borrow ? rem_i : trial[DW-1:0];
        rem_o  = {kept[DW-2:0], 1'b0};
        quo_o  = {quo_i[W-2:0], !borrow};
    end
endmodule

// File: rtl/wide_restoring_div.sv
module wide_restoring_div #(
    parameter int W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2*W-1:0]   dividend_i,
    input  logic [W-1:0]     divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [W-1:0]     quotient_o,
    output logic [W-1:0]     remainder_o
);
    import wdiv_pkg::*;

    localparam int DW = 2 * W;
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] ITERS = CW'(W);
    localparam logic [CW-1:0] LAST  = CW'(1);

    typedef struct packed {
        wdiv_state_e    st;
        logic [CW-1:0]  cnt;
        logic [DW-1:0]  rem;
        logic [DW-1:0]  aligned;
        logic [W-1:0]   quo;
        logic           done;
        logic           err;
    } regs_t;

    regs_t r_q, r_d;

    logic          ops_valid;
    logic [DW-1:0] aligned_in;
    logic [DW-1:0] rem_step;
    logic [W-1:0]  quo_step;

    wdiv_opcheck #(.W(W)) opcheck_i (
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .valid_o    (ops_valid)
    );

    wdiv_align #(.W(W)) align_i (
        .divisor_i (divisor_i),
        .aligned_o (aligned_in)
    );

    wdiv_step #(.W(W)) step_i (
        .rem_i     (r_q.rem),
        .aligned_i (r_q.aligned),
        .quo_i     (r_q.quo),
        .rem_o     (rem_step),
        .quo_o     (quo_step)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (ops_valid) begin
                        r_d.st      = ST_RUN;
                        r_d.cnt     = ITERS;
                        r_d.rem     = dividend_i;
                        r_d.aligned = aligned_in;
                        r_d.quo     = '0;
                        r_d.err     = 1'b0;
                    end else begin
                        r_d.rem     = '0;
                        r_d.quo     = '0;
                        r_d.err     = 1'b1;
                        r_d.done    = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                r_d.rem = rem_step;
                r_d.quo = quo_step;
                r_d.cnt = r_q.cnt - 1'b1;
                if (r_q.cnt == LAST) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, rem: '0, aligned: '0,
                     quo: '0, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = (r_q.st == ST_RUN);
    assign done_o      = r_q.done;
    assign err_o       = r_q.err;
    assign quotient_o  = r_q.quo;
    assign remainder_o = r_q.rem[DW-1:W];
endmodule

// File: rtl/wdiv_chk.sv
module wdiv_chk #(
    parameter int W = 256
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic [2*W-1:0] dividend_i,
    input logic [W-1:0]   divisor_i,
    input logic           busy_o,
    input logic           done_o,
    input logic           err_o,
    input logic [W-1:0]   quotient_o,
    input logic [W-1:0]   remainder_o
);
    localparam int CW = $clog2(W + 1) + 1;

    logic [CW-1:0] run_len;
    logic          bad_ops;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_len <= '0;
        else if (busy_o) run_len <= run_len + 1'b1;
        else             run_len <= '0;
    end

    assign bad_ops = (divisor_i == '0) || (dividend_i[2*W-1:W] >= divisor_i);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !busy_o && !done_o && !err_o);

    // R2
    bad_ops_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i && bad_ops |=> done_o && err_o && !busy_o);

    // R2
    err_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && err_o |-> quotient_o == '0 && remainder_o == '0);

    // R3
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R3
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !err_o |-> run_len == CW'(W));

    // R7
    busy_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o && !err_o);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !start_i |=> $stable(quotient_o) && $stable(remainder_o));
endmodule

bind wide_restoring_div wdiv_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o)
);

// File: tb/wide_restoring_div_tb_top.sv
module wide_restoring_div_tb_top;
    localparam int W       = 256;
    localparam int DW      = 2 * W;
    localparam int CLK_PER = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [DW-1:0]  dividend_i = '0;
    logic [W-1:0]   divisor_i = '0;
    logic           busy_o, done_o, err_o;
    logic [W-1:0]   quotient_o, remainder_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PER / 2) clk = ~clk;

    wide_restoring_div #(.W(W)) dut_i (
        .clk, .rst_n, .start_i, .dividend_i, .divisor_i,
        .busy_o, .done_o, .err_o, .quotient_o, .remainder_o
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rand_w();
        logic [W-1:0] v = '0;
        for (int i = 0; i < W / 32; i++) v = {v[W-33:0], $urandom()};
        return v;
    endfunction

    // Runs one request; poke injects a start mid-run (R7).
    task automatic run_op(input logic [DW-1:0] n, input logic [W-1:0] d,
                          input bit poke, input string tag);
        logic [DW-1:0] eq, er;
        bit            bad;
        int            cyc;
        bad = (d == '0) || (n[DW-1:W] >= d);
        eq  = bad ? '0 : n / DW'(d);
        er  = bad ? '0 : n % DW'(d);
        @(negedge clk);
        dividend_i = n; divisor_i = d; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; dividend_i = rand_w(); divisor_i = rand_w();
        cyc = 1;
        while (!done_o && cyc < W + 8) begin
            chk(busy_o == !bad, {tag, " R3 busy"}, DW'(busy_o), DW'(!bad));
            if (!bad && cyc == 1 + W / 2)
                chk(quotient_o == W'(eq >> (W / 2)), {tag, " R5 msb-first"},
                    DW'(quotient_o), eq >> (W / 2));
            if (poke && cyc == 3) begin
                start_i = 1'b1; divisor_i = '0;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        if (bad) begin
            chk(cyc == 1, {tag, " R2 latency"}, DW'(cyc), DW'(1));
            chk(err_o && quotient_o == '0 && remainder_o == '0, {tag, " R2 err/zero"},
                DW'({err_o, quotient_o}), DW'({1'b1, W'(0)}));
        end else begin
            chk(cyc == W + 1, {tag, " R3 latency"}, DW'(cyc), DW'(W + 1));
            chk(!err_o && !busy_o, {tag, " R3 err low"}, DW'({err_o, busy_o}), '0);
            chk(DW'(quotient_o) == eq, {tag, " R4 quotient"}, DW'(quotient_o), eq);
            chk(DW'(remainder_o) == er, {tag, " R4 remainder"}, DW'(remainder_o), er);
        end
        repeat (2) @(negedge clk);
        chk(!done_o, {tag, " R6 pulse"}, DW'(done_o), '0);
        chk(DW'(quotient_o) == eq && DW'(remainder_o) == er, {tag, " R6 hold"},
            {quotient_o, remainder_o}, {eq[W-1:0], er[W-1:0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] d, hi;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1
        chk(!busy_o && !done_o && !err_o && quotient_o == '0 && remainder_o == '0,
            "R1 reset", DW'({busy_o, done_o, err_o}), '0);
        rst_n = 1'b1;
        // R8 corner cases
        run_op(DW'(1) << (W - 1), W'(1), 1'b0, "R8 pow2/1");
        run_op((DW'(1) << (DW - 1)) - 1, {W{1'b1}}, 1'b0, "R8 max/max");
        // R2 invalid requests
        run_op(rand_w(), '0, 1'b0, "R2 zero");
        d = rand_w() | W'(1);
        run_op({d, rand_w()}, d, 1'b0, "R2 equal");
        run_op({{W{1'b1}}, rand_w()}, W'(5), 1'b0, "R2 over");
        // R7 start during run
        d = rand_w() | W'(1);
        run_op({rand_w() % d, rand_w()}, d, 1'b1, "R7 poke");
        // R4 random
        for (int i = 0; i < 24; i++) begin
            unique case (i % 3)
                0: d = rand_w() | W'(1);
                1: d = W'($urandom_range(1, 1000));
                default: d = {W{1'b1}};
            endcase
            hi = rand_w() % d;
            run_op({hi, rand_w()}, d, (i % 5) == 0, "R4 random");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule